// File: doc/BRIEF.md
# Lockstep Vector Prefetch Collector

This block fetches data ahead of a compute loop that walks several parallel arrays with one shared iteration index. Each of the NS streams is described by a base byte address and an element size (1, 2 or 4 bytes). All streams share one element count and a tile size of 2^k elements. After a `start` pulse the collector converts indices into line addresses and sends one read per distinct line on a request/response memory port. The tag it attaches to each request steers the returned line into a double-buffered staging store. The tag encodes tile parity, stream and line slot.

The compute side never forms an address. It presents a stream number and an element index, and it gets back the zero-extended element together with a valid flag. Fetching runs at most one tile ahead of the tile being consumed. When compute pulses `tile_done`, the oldest tile is released and its half of the store is freed for the tile after next. `done` rises once every tile, including a short final one, has been released.

The configuration inputs must stay stable from `start` until `done`. Every base address must be aligned to its element size, and `cfg_tile_log` must not exceed `TMAX_LOG`.

Top module: `vec_collector`

## Requirements
- R1: A request for stream s carries a line address. That address is the line containing base_s + (i << esz_s) for some element i of the tile being filled. Its low LB_LOG bits are zero (lines are 2^LB_LOG bytes, 8 by default).
- R2: Within one tile, each stream requests each line touched by that tile's elements exactly once, in ascending address order. Streams are served in order 0 to NS-1.
- R3: All streams are requested for tile k before any request for tile k+1 is made.
- R4: No request is made for tile c+2 or later while tile c is the oldest unreleased tile.
- R5: The request tag is {tile parity (MSB), stream (next SW bits), slot (low SLW bits)}. The slot is the line's distance from the first line of that stream's tile. A response with a given tag lands in that entry whatever the order of responses.
- R6: `rd_valid` is high only when all three hold: the index is below the length, it lies in the oldest unreleased tile or the one after it, and its line has arrived. `rd_data` is then the little-endian element, zero-extended. Otherwise `rd_valid` is low and `rd_data` is zero.
- R7: `tile_done` releases the oldest tile and invalidates its store half. Data of a released tile is never returned for the tile that reuses that half.
- R8: Fetching stops at the configured length, so the last tile may be partial. `done` is high exactly when every tile has been released, and no request is made while `done` is high.
- R9: A request that is not accepted stays asserted with unchanged address and tag.
- R10: `start` discards all staged data and restarts fetching from tile 0 with the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new run with the present configuration |
| cfg_base | input | NS*AW | Per-stream base byte address, stream s at [s*AW +: AW] |
| cfg_esz | input | NS*2 | Per-stream log2 element size (0, 1 or 2) |
| cfg_len | input | NW | Element count shared by all streams |
| cfg_tile_log | input | 4 | log2 of the tile size in elements |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Line-aligned byte address |
| mem_req_tag | output | TGW | {parity, stream, slot} tag |
| mem_rsp_valid | input | 1 | Response line valid |
| mem_rsp_tag | input | TGW | Tag of the returning line |
| mem_rsp_data | input | LW | Returned line, byte 0 in the low bits |
| rd_stream | input | SW | Stream selected by compute |
| rd_idx | input | NW | Element index requested by compute |
| rd_valid | output | 1 | Requested element is staged |
| rd_data | output | EW | Element value, zero-extended |
| tile_done | input | 1 | Compute has finished the oldest tile |
| done | output | 1 | All tiles consumed |

## Verification
The hardest case to reach is the reuse of a store half. Tile k+2 has been requested but has not yet returned, while the valid bits left by tile k would still point at stale lines. The bench holds all memory responses after the first two tiles are staged and releases tile 0. It then reads an index of tile 2 that maps to a slot tile 0 had filled, and this read must come back invalid. Responses are otherwise returned newest-first once several are pending, so tag steering is exercised out of order. A second run restarts with a stalled memory port to check request holding and the discard of old data.

// File: rtl/vec_collector.sv
module vec_collector #(
  parameter int NS       = 2,
  parameter int AW       = 16,
  parameter int NW       = 12,
  parameter int LB_LOG   = 3,
  parameter int TMAX_LOG = 3,
  parameter int EW       = 32,
  localparam int SW  = (NS > 1) ? $clog2(NS) : 1,
  localparam int NL  = (((1 << TMAX_LOG) * (EW / 8)) >> LB_LOG) + 1,
  localparam int SLW = $clog2(NL),
  localparam int TGW = 1 + SW + SLW,
  localparam int LW  = 8 << LB_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NS*AW-1:0] cfg_base,
  input  logic [NS*2-1:0]  cfg_esz,
  input  logic [NW-1:0]    cfg_len,
  input  logic [3:0]       cfg_tile_log,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  output logic [TGW-1:0]   mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [TGW-1:0]   mem_rsp_tag,
  input  logic [LW-1:0]    mem_rsp_data,
  input  logic [SW-1:0]    rd_stream,
  input  logic [NW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [EW-1:0]    rd_data,
  input  logic             tile_done,
  output logic             done
);
  localparam int LAW = AW - LB_LOG;
  localparam int XW  = NW + TMAX_LOG + 2;

  logic          run;
  logic [NW:0]   ftile, ctile;
  logic [SW-1:0] fs;
  logic [SLW-1:0] fslot;
  logic [1:0][NS-1:0][NL-1:0] vld;
  logic [LW-1:0] store [2][NS][NL];

  function automatic logic [LAW-1:0] line_of(logic [AW-1:0] b, logic [1:0] e, logic [XW-1:0] i);
    logic [AW-1:0] a;
    a = b + (AW'(i) << e);
    return a[AW-1:LB_LOG];
  endfunction

  wire [XW-1:0] len_x = XW'(cfg_len);
  wire [XW-1:0] tsz   = XW'(1) << cfg_tile_log;

  // fill side
  wire [AW-1:0]  fb      = cfg_base[fs*AW +: AW];
  wire [1:0]     fe      = cfg_esz[fs*2 +: 2];
  wire [XW-1:0]  f_first = XW'(ftile) << cfg_tile_log;
  wire [XW-1:0]  f_end   = (f_first + tsz > len_x) ? len_x : f_first + tsz;
  wire [LAW-1:0] f_fl    = line_of(fb, fe, f_first);
  wire [LAW-1:0] f_ll    = line_of(fb, fe, f_end - 1);
  wire [LAW-1:0] f_cur   = f_fl + LAW'(fslot);
  wire [NW:0]    ahead   = ftile - ctile;

  assign done          = run && ((XW'(ctile) << cfg_tile_log) >= len_x);
  assign mem_req_valid = run && (f_first < len_x) && (ahead < 2);
  assign mem_req_addr  = {f_cur, {LB_LOG{1'b0}}};
  assign mem_req_tag   = {ftile[0], fs, fslot};

  // read side
  wire [AW-1:0]  rb      = cfg_base[rd_stream*AW +: AW];
  wire [1:0]     re      = cfg_esz[rd_stream*2 +: 2];
  wire [XW-1:0]  r_tile  = XW'(rd_idx) >> cfg_tile_log;
  wire [XW-1:0]  r_first = r_tile << cfg_tile_log;
  wire [AW-1:0]  r_addr  = rb + (AW'(rd_idx) << re);
  wire [SLW-1:0] r_slot  = SLW'(r_addr[AW-1:LB_LOG] - line_of(rb, re, r_first));
  wire           r_buf   = r_tile[0];
  wire           r_win   = run && (rd_idx < cfg_len) &&
                           (r_tile == XW'(ctile) || r_tile == XW'(ctile) + 1);
  wire [LW-1:0]  r_sh    = store[r_buf][rd_stream][r_slot] >> {r_addr[LB_LOG-1:0], 3'b000};

  assign rd_valid = r_win && vld[r_buf][rd_stream][r_slot];
  assign rd_data  = !rd_valid ? '0 :
                    (re == 2'd0) ? EW'(r_sh[7:0]) :
                    (re == 2'd1) ? EW'(r_sh[15:0]) : r_sh[EW-1:0];

  wire           w_buf  = mem_rsp_tag[TGW-1];
  wire [SW-1:0]  w_str  = mem_rsp_tag[SLW +: SW];
  wire [SLW-1:0] w_slot = mem_rsp_tag[SLW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      ftile <= '0;
      ctile <= '0;
      fs    <= '0;
      fslot <= '0;
      vld   <= '0;
    end else if (start) begin
      run   <= 1'b1;
      ftile <= '0;
      ctile <= '0;
      fs    <= '0;
      fslot <= '0;
      vld   <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        if (f_cur == f_ll) begin
          fslot <= '0;
          if (fs == SW'(NS - 1)) begin
            fs    <= '0;
            ftile <= ftile + 1'b1;
          end else begin
            fs <= fs + 1'b1;
          end
        end else begin
          fslot <= fslot + 1'b1;
        end
      end
      if (run && !done && tile_done) begin
        vld[ctile[0]] <= '0;
        ctile         <= ctile + 1'b1;
      end
      if (mem_rsp_valid)
        vld[w_buf][w_str][w_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_rsp_valid)
      store[w_buf][w_str][w_slot] <= mem_rsp_data;
  end
endmodule

// File: rtl/vec_collector_chk.sv
module vec_collector_chk #(
  parameter int AW     = 16,
  parameter int NW     = 12,
  parameter int TGW    = 5,
  parameter int LB_LOG = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic [TGW-1:0] mem_req_tag,
  input logic           rd_valid,
  input logic [NW-1:0]  rd_idx,
  input logic [NW-1:0]  cfg_len,
  input logic           done,
  input logic [NW:0]    ftile,
  input logic [NW:0]    ctile
);
  a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[LB_LOG-1:0] == '0);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !start) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag)));

  a_r2_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !start) |=>
      !(mem_req_valid && mem_req_addr == $past(mem_req_addr) && mem_req_tag == $past(mem_req_tag)));

  a_r4_one_tile_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (ftile - ctile) <= 1);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

  a_r6_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_idx < cfg_len);
endmodule

bind vec_collector vec_collector_chk #(.AW(AW), .NW(NW), .TGW(TGW), .LB_LOG(LB_LOG)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
  .rd_valid(rd_valid), .rd_idx(rd_idx), .cfg_len(cfg_len),
  .done(done), .ftile(ftile), .ctile(ctile)
);

// File: tb/vec_collector_tb.sv
module vec_collector_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] cfg_base = '0;
  logic [3:0]  cfg_esz = '0;
  logic [11:0] cfg_len = '0;
  logic [3:0]  cfg_tile_log = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [15:0] mem_req_addr;
  logic [4:0]  mem_req_tag;
  logic        mem_rsp_valid = 0;
  logic [4:0]  mem_rsp_tag = '0;
  logic [63:0] mem_rsp_data = '0;
  logic        rd_stream = 0;
  logic [11:0] rd_idx = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        tile_done = 0;
  logic        done;

  always #2.5 clk = ~clk;

  vec_collector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base), .cfg_esz(cfg_esz),
    .cfg_len(cfg_len), .cfg_tile_log(cfg_tile_log),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .rd_stream(rd_stream), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .tile_done(tile_done), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit rdy_en = 0, rsp_en = 1, lifo = 1;

  logic [15:0] pend_addr [0:63];
  logic [4:0]  pend_tag  [0:63];
  int          pcount = 0;
  logic [15:0] lg_addr [0:63];
  logic [4:0]  lg_tag  [0:63];
  int          lcount = 0;
  logic [15:0] ex_addr [0:63];
  logic [4:0]  ex_tag  [0:63];
  int          ecount = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    logic [15:0] v;
    v = a * 16'd7 + 16'd3;
    return v[7:0];
  endfunction

  function automatic logic [63:0] mline(input logic [15:0] a);
    logic [63:0] d = '0;
    for (int j = 0; j < 8; j++) d[j*8 +: 8] = mbyte(a + 16'(j));
    return d;
  endfunction

  function automatic logic [31:0] exp_el(input logic [15:0] b, input int e, input int i);
    logic [31:0] v = '0;
    logic [15:0] a;
    a = b + 16'(i << e);
    for (int j = 0; j < (1 << e); j++) v[j*8 +: 8] = mbyte(a + 16'(j));
    return v;
  endfunction

  // memory model: accepts and logs requests, replies newest-first (lifo) or oldest-first
  initial begin
    forever begin
      @(negedge clk);
      #1;
      mem_req_ready = rdy_en;
      mem_rsp_valid = 0;
      if (rsp_en && pcount > 0 && (!lifo || pcount >= 3 || !(mem_req_valid && rdy_en))) begin
        if (lifo) begin
          pcount--;
          mem_rsp_tag  = pend_tag[pcount];
          mem_rsp_data = mline(pend_addr[pcount]);
        end else begin
          mem_rsp_tag  = pend_tag[0];
          mem_rsp_data = mline(pend_addr[0]);
          for (int k = 1; k < pcount; k++) begin
            pend_tag[k-1]  = pend_tag[k];
            pend_addr[k-1] = pend_addr[k];
          end
          pcount--;
        end
        mem_rsp_valid = 1;
      end
      if (mem_req_valid && rdy_en && rst_n && !start) begin
        pend_addr[pcount] = mem_req_addr;
        pend_tag[pcount]  = mem_req_tag;
        pcount++;
        if (lcount < 64) begin
          lg_addr[lcount] = mem_req_addr;
          lg_tag[lcount]  = mem_req_tag;
        end
        lcount++;
      end
    end
  end

  task automatic build_exp(input int len, input int tl, input int max_tiles);
    ecount = 0;
    for (int t = 0; (t << tl) < len && t < max_tiles; t++)
      for (int s = 0; s < 2; s++) begin
        int first, last, e;
        logic [15:0] b, fl, ll;
        b = cfg_base[s*16 +: 16];
        e = int'(cfg_esz[s*2 +: 2]);
        first = t << tl;
        last = ((first + (1 << tl)) > len ? len : first + (1 << tl)) - 1;
        fl = (b + 16'(first << e)) >> 3;
        ll = (b + 16'(last << e)) >> 3;
        for (logic [15:0] l = fl; l <= ll; l++) begin
          ex_addr[ecount] = l << 3;
          ex_tag[ecount]  = {t[0], s[0], 3'(l - fl)};
          ecount++;
        end
      end
  endtask

  task automatic check_log(input string req);
    chk(lcount == ecount, req, lcount, ecount);
    for (int k = 0; k < ecount && k < lcount; k++) begin
      chk(lg_addr[k] == ex_addr[k], "R1 R2 request address", lg_addr[k], ex_addr[k]);
      chk(lg_tag[k] == ex_tag[k], "R3 R5 request tag", lg_tag[k], ex_tag[k]);
    end
  endtask

  task automatic read_at(input int s, input int i);
    @(negedge clk);
    rd_stream = s[0];
    rd_idx = 12'(i);
    #2;
  endtask

  task automatic consume_tile(input int t, input int len, input int tl);
    for (int i = t << tl; i < ((t + 1) << tl) && i < len; i++)
      for (int s = 0; s < 2; s++) begin
        int w = 0;
        read_at(s, i);
        while (!rd_valid && w < 300) begin read_at(s, i); w++; end
        chk(rd_valid, "R6 element staged", rd_valid, 1);
        chk(rd_data == exp_el(cfg_base[s*16 +: 16], int'(cfg_esz[s*2 +: 2]), i),
            "R5 R6 element data", rd_data,
            exp_el(cfg_base[s*16 +: 16], int'(cfg_esz[s*2 +: 2]), i));
      end
    chk(done == 0, "R8 done before last release", done, 0);
    @(negedge clk); tile_done = 1;
    @(negedge clk); tile_done = 0;
    read_at(0, t << tl);
    chk(rd_valid == 0, "R7 released tile unreadable", rd_valid, 0);
  endtask

  task automatic pulse_start;
    @(negedge clk); lcount = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(mem_req_valid == 0 && done == 0 && rd_valid == 0, "R8 reset idle",
        {mem_req_valid, done, rd_valid}, 0);
  endtask

  task automatic t_run_out_of_order;
    cfg_base = {16'h0203, 16'h0100};
    cfg_esz = {2'd0, 2'd2};
    cfg_len = 12'd10;
    cfg_tile_log = 4'd2;
    rdy_en = 1; rsp_en = 1; lifo = 1;
    pulse_start();
    repeat (60) @(negedge clk);
    build_exp(10, 2, 2);
    check_log("R4 window requests");
    read_at(0, 8);
    chk(rd_valid == 0 && rd_data == 0, "R6 index beyond window", rd_valid, 0);
    read_at(1, 12);
    chk(rd_valid == 0, "R6 index beyond length", rd_valid, 0);
    rsp_en = 0;
    consume_tile(0, 10, 2);
    repeat (20) @(negedge clk);
    read_at(0, 8);
    chk(rd_valid == 0, "R7 stale half invalidated", rd_valid, 0);
    rsp_en = 1;
    consume_tile(1, 10, 2);
    consume_tile(2, 10, 2);
    #1;
    chk(done == 1, "R8 done after partial tile", done, 1);
    build_exp(10, 2, 100);
    check_log("R8 total requests stop at length");
  endtask

  task automatic t_restart_stalled;
    rdy_en = 0; lifo = 0;
    cfg_base = {16'h0400, 16'h0300};
    cfg_esz = {2'd2, 2'd1};
    cfg_len = 12'd5;
    cfg_tile_log = 4'd1;
    pulse_start();
    read_at(0, 0);
    chk(rd_valid == 0, "R10 old data discarded", rd_valid, 0);
    chk(done == 0, "R10 done cleared", done, 0);
    begin
      logic [15:0] a0;
      a0 = mem_req_addr;
      chk(mem_req_valid && a0 == 16'h0300, "R10 restart from tile 0", a0, 16'h0300);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); #2;
        chk(mem_req_valid && mem_req_addr == a0, "R9 stalled request held", mem_req_addr, a0);
      end
    end
    chk(lcount == 0, "R9 nothing accepted", lcount, 0);
    rdy_en = 1;
    repeat (40) @(negedge clk);
    build_exp(5, 1, 2);
    check_log("R4 R5 second config window");
    for (int t = 0; t < 3; t++) consume_tile(t, 5, 1);
    #1;
    chk(done == 1, "R8 done second run", done, 1);
    chk(mem_req_valid == 0, "R8 quiet when done", mem_req_valid, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_run_out_of_order();
    t_restart_stalled();
    finish_run();
  end
endmodule